// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Controller

This block drives the two interrupt lines of a real-time clock. It watches the BCD weekday, hour and minute values that the timekeeping counters present. On each minute carry it compares them with two programmed alarms. The weekly alarm matches on weekday, hour and minute. The daily alarm matches on hour and minute only.

A periodic source runs beside the alarms. A 3-bit rate field selects it. It either produces a 50% square wave from a 4 Hz prescaler tick or raises a held level at each second, minute, hour or month boundary. The host reaches the alarm values, the enables, the rate and the sticky status flags through a small register port.

The weekly alarm owns its own active-low pin. The daily alarm and the periodic source share the second pin as a wired-low OR. Software separates the two sources by reading the status flags.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset both interrupt pins are high, and every register reads 0.
- R2: The register map is 0x8 weekly minute (7 bits), 0x9 weekly hour (6 bits), 0xA weekly weekday (3 bits), 0xB daily minute (7 bits), 0xC daily hour (6 bits), 0xE control, 0xF status. Reads are combinational. Bits beyond each field, and all other addresses, read 0.
- R3: On a cycle with `min_tick_i` high, the weekly flag (status bit 1) is set in the next cycle when weekday, hour and minute all equal the weekly alarm. Nothing else sets it.
- R4: On a cycle with `min_tick_i` high, the daily flag (status bit 0) is set when hour and minute equal the daily alarm, whatever the weekday.
- R5: `irq_wk_n_o` is low exactly while the weekly flag and the weekly enable (control bit 7) are both 1.
- R6: `irq_day_n_o` is low while the daily flag and the daily enable (control bit 6) are both 1, OR while the periodic source asserts.
- R7: Flags are sticky. Writing 0 to a status bit clears it, and writing 1 has no effect. A set event in the same cycle as a clear wins.
- R8: Clearing an enable bit releases its pin in the next cycle and leaves the flag unchanged.
- R9: Rate 001 makes the periodic output toggle on every `tick_4hz_i`, giving 2 Hz. Rate 010 makes it toggle on every second tick, giving 1 Hz. Each half period starts high (inactive). Any write to control restarts the phase high. In these modes status bit 2 reads 1 while the output is low.
- R10: Rates 011, 100, 101 and 110 set the periodic flag (status bit 2) on `sec_tick_i`, `min_tick_i`, `hour_tick_i` and `mon_tick_i` respectively. The pin then stays low until the flag is cleared or the rate leaves level mode.
- R11: Rates 000 and 111 produce no periodic output and set no periodic flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wday_i | input | 3 | Current weekday |
| hour_i | input | 6 | Current hour, BCD |
| min_i | input | 7 | Current minute, BCD |
| tick_4hz_i | input | 1 | One-cycle 4 Hz prescaler strobe |
| sec_tick_i | input | 1 | One-cycle seconds carry |
| min_tick_i | input | 1 | One-cycle minute carry |
| hour_tick_i | input | 1 | One-cycle hour carry |
| mon_tick_i | input | 1 | One-cycle month carry |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| irq_day_n_o | output | 1 | Daily alarm / periodic interrupt, active low |
| irq_wk_n_o | output | 1 | Weekly alarm interrupt, active low |

## Verification
A flag latched at the wrong time shows up twice. The status read exposes it, and its pin follows one cycle after the minute carry or boundary tick, provided the enable is set. A wrong phase count shows within a single 4 Hz tick, as a pin toggle that is missing or comes too early. A wrong restart shows on the first cycle after a control write. Because the two sources are ORed, a stuck-low periodic term would mask the daily alarm's release. The bench therefore clears each source separately and watches the shared pin return high.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DW      = 8;
  localparam int AW      = 4;
  localparam int NUM_ALM = 2;
  localparam int IDX_WK  = 0;
  localparam int IDX_DY  = 1;

  typedef enum logic [2:0] {
    RATE_OFF  = 3'd0,
    RATE_2HZ  = 3'd1,
    RATE_1HZ  = 3'd2,
    RATE_SEC  = 3'd3,
    RATE_MIN  = 3'd4,
    RATE_HOUR = 3'd5,
    RATE_MON  = 3'd6,
    RATE_RSV  = 3'd7
  } rate_e;

  localparam logic [AW-1:0] A_WK_MIN  = 4'h8;
  localparam logic [AW-1:0] A_WK_HOUR = 4'h9;
  localparam logic [AW-1:0] A_WK_WDAY = 4'hA;
  localparam logic [AW-1:0] A_DY_MIN  = 4'hB;
  localparam logic [AW-1:0] A_DY_HOUR = 4'hC;
  localparam logic [AW-1:0] A_CTRL    = 4'hE;
  localparam logic [AW-1:0] A_STAT    = 4'hF;

  localparam int CTL_WK_EN = 7;
  localparam int CTL_DY_EN = 6;
  localparam int ST_PR     = 2;
  localparam int ST_WK     = 1;
  localparam int ST_DY     = 0;
endpackage

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter bit USE_WDAY = 1'b1,
  parameter int WD_W     = 3,
  parameter int HR_W     = 6,
  parameter int MN_W     = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            min_tick_i,
  input  logic [WD_W-1:0] cur_wday_i,
  input  logic [HR_W-1:0] cur_hour_i,
  input  logic [MN_W-1:0] cur_min_i,
  input  logic [WD_W-1:0] alm_wday_i,
  input  logic [HR_W-1:0] alm_hour_i,
  input  logic [MN_W-1:0] alm_min_i,
  input  logic            clr_i,
  output logic            flag_o
);
  logic wday_ok, hit;

  assign wday_ok = USE_WDAY ? (cur_wday_i == alm_wday_i) : 1'b1;
  assign hit     = min_tick_i && wday_ok &&
                   (cur_hour_i == alm_hour_i) && (cur_min_i == alm_min_i);

  // a match beats a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rate_e rate_i,
  input  logic  restart_i,
  input  logic  tick_4hz_i,
  input  logic  sec_tick_i,
  input  logic  min_tick_i,
  input  logic  hour_tick_i,
  input  logic  mon_tick_i,
  input  logic  clr_i,
  output logic  pulse_mode_o,
  output logic  level_mode_o,
  output logic  pulse_low_o,
  output logic  level_flag_o
);
  logic [1:0] phase_q;
  logic       boundary;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= '0;
    else if (restart_i)  phase_q <= '0;
    else if (tick_4hz_i) phase_q <= phase_q + 2'd1;
  end

  always_comb begin
    pulse_mode_o = 1'b0;
    level_mode_o = 1'b0;
    pulse_low_o  = 1'b0;
    boundary     = 1'b0;
    case (rate_i)
      RATE_2HZ:  begin pulse_mode_o = 1'b1; pulse_low_o = phase_q[0]; end
      RATE_1HZ:  begin pulse_mode_o = 1'b1; pulse_low_o = phase_q[1]; end
      RATE_SEC:  begin level_mode_o = 1'b1; boundary = sec_tick_i;  end
      RATE_MIN:  begin level_mode_o = 1'b1; boundary = min_tick_i;  end
      RATE_HOUR: begin level_mode_o = 1'b1; boundary = hour_tick_i; end
      RATE_MON:  begin level_mode_o = 1'b1; boundary = mon_tick_i;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       level_flag_o <= 1'b0;
    else if (boundary) level_flag_o <= 1'b1;
    else if (clr_i)    level_flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int WD_W = 3,
  parameter int HR_W = 6,
  parameter int MN_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WD_W-1:0] wday_i,
  input  logic [HR_W-1:0] hour_i,
  input  logic [MN_W-1:0] min_i,
  input  logic            tick_4hz_i,
  input  logic            sec_tick_i,
  input  logic            min_tick_i,
  input  logic            hour_tick_i,
  input  logic            mon_tick_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_day_n_o,
  output logic            irq_wk_n_o
);
  logic [MN_W-1:0] alm_min_q  [NUM_ALM];
  logic [HR_W-1:0] alm_hour_q [NUM_ALM];
  logic [WD_W-1:0] alm_wday_q;
  logic            wk_en_q, dy_en_q;
  rate_e           rate_q;
  logic [NUM_ALM-1:0] alm_flag, clr_alm;
  logic            ctrl_wr, stat_wr;
  logic            pulse_mode, level_mode, pulse_low, lvl_flag;

  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  assign stat_wr = we_i && (addr_i == A_STAT);
  assign clr_alm[IDX_WK] = stat_wr && !wdata_i[ST_WK];
  assign clr_alm[IDX_DY] = stat_wr && !wdata_i[ST_DY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_min_q  <= '{default: '0};
      alm_hour_q <= '{default: '0};
      alm_wday_q <= '0;
      wk_en_q    <= 1'b0;
      dy_en_q    <= 1'b0;
      rate_q     <= RATE_OFF;
    end else if (we_i) begin
      case (addr_i)
        A_WK_MIN:  alm_min_q[IDX_WK]  <= wdata_i[MN_W-1:0];
        A_WK_HOUR: alm_hour_q[IDX_WK] <= wdata_i[HR_W-1:0];
        A_WK_WDAY: alm_wday_q         <= wdata_i[WD_W-1:0];
        A_DY_MIN:  alm_min_q[IDX_DY]  <= wdata_i[MN_W-1:0];
        A_DY_HOUR: alm_hour_q[IDX_DY] <= wdata_i[HR_W-1:0];
        A_CTRL: begin
          wk_en_q <= wdata_i[CTL_WK_EN];
          dy_en_q <= wdata_i[CTL_DY_EN];
          rate_q  <= rate_e'(wdata_i[2:0]);
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    rtc_alarm_unit #(
      .USE_WDAY(i == IDX_WK), .WD_W(WD_W), .HR_W(HR_W), .MN_W(MN_W)
    ) u_alm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .min_tick_i (min_tick_i),
      .cur_wday_i (wday_i),
      .cur_hour_i (hour_i),
      .cur_min_i  (min_i),
      .alm_wday_i (alm_wday_q),
      .alm_hour_i (alm_hour_q[i]),
      .alm_min_i  (alm_min_q[i]),
      .clr_i      (clr_alm[i]),
      .flag_o     (alm_flag[i])
    );
  end

  rtc_periodic_gen u_per (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rate_i       (rate_q),
    .restart_i    (ctrl_wr),
    .tick_4hz_i   (tick_4hz_i),
    .sec_tick_i   (sec_tick_i),
    .min_tick_i   (min_tick_i),
    .hour_tick_i  (hour_tick_i),
    .mon_tick_i   (mon_tick_i),
    .clr_i        (stat_wr && !wdata_i[ST_PR]),
    .pulse_mode_o (pulse_mode),
    .level_mode_o (level_mode),
    .pulse_low_o  (pulse_low),
    .level_flag_o (lvl_flag)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_WK_MIN:  rdata_o[MN_W-1:0] = alm_min_q[IDX_WK];
      A_WK_HOUR: rdata_o[HR_W-1:0] = alm_hour_q[IDX_WK];
      A_WK_WDAY: rdata_o[WD_W-1:0] = alm_wday_q;
      A_DY_MIN:  rdata_o[MN_W-1:0] = alm_min_q[IDX_DY];
      A_DY_HOUR: rdata_o[HR_W-1:0] = alm_hour_q[IDX_DY];
      A_CTRL: begin
        rdata_o[CTL_WK_EN] = wk_en_q;
        rdata_o[CTL_DY_EN] = dy_en_q;
        rdata_o[2:0]       = rate_q;
      end
      A_STAT: begin
        rdata_o[ST_PR] = pulse_mode ? pulse_low : lvl_flag;
        rdata_o[ST_WK] = alm_flag[IDX_WK];
        rdata_o[ST_DY] = alm_flag[IDX_DY];
      end
      default: ;
    endcase
  end

  // shared pin: wired-low OR of daily alarm and periodic source
  assign irq_day_n_o = !((alm_flag[IDX_DY] && dy_en_q) || pulse_low ||
                         (level_mode && lvl_flag));
  assign irq_wk_n_o  = !(alm_flag[IDX_WK] && wk_en_q);
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [3:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       tick_4hz_i,
  input logic       min_tick_i,
  input logic       irq_day_n_o,
  input logic       irq_wk_n_o,
  input logic       wk_flag_i,
  input logic       dy_flag_i,
  input logic       dy_en_i,
  input logic [2:0] rate_i,
  input logic       lvl_flag_i
);
  // R3
  wk_set_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wk_flag_i) |-> $past(min_tick_i));

  // R7
  dy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'hF && !wdata_i[0] && !min_tick_i) |=> !dy_flag_i);

  // R7
  dy_write_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'hF && !dy_flag_i && !min_tick_i) |=> !dy_flag_i);

  // R8
  wk_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'hE && !wdata_i[7]) |=> irq_wk_n_o);

  // R8
  wk_flag_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'hE && wk_flag_i) |=> wk_flag_i);

  // R9
  pulse_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == 3'd1 && tick_4hz_i && !we_i && !min_tick_i && !(dy_flag_i && dy_en_i))
    |=> (irq_day_n_o != $past(irq_day_n_o)));

  // R10
  lvl_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_flag_i) |-> ($past(rate_i) >= 3'd3 && $past(rate_i) <= 3'd6));

  // R11
  rate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rate_i == 3'd0 || rate_i == 3'd7) && !(dy_flag_i && dy_en_i)) |-> irq_day_n_o);
endmodule

bind rtc_irq_ctrl rtc_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .tick_4hz_i  (tick_4hz_i),
  .min_tick_i  (min_tick_i),
  .irq_day_n_o (irq_day_n_o),
  .irq_wk_n_o  (irq_wk_n_o),
  .wk_flag_i   (alm_flag[0]),
  .dy_flag_i   (alm_flag[1]),
  .dy_en_i     (dy_en_q),
  .rate_i      (rate_q),
  .lvl_flag_i  (lvl_flag)
);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] wday = '0;
  logic [5:0] hour = '0;
  logic [6:0] min = '0;
  logic       t4 = 0, sec_t = 0, min_t = 0, hour_t = 0, mon_t = 0;
  logic       we = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_day_n, irq_wk_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wday_i(wday), .hour_i(hour), .min_i(min),
    .tick_4hz_i(t4), .sec_tick_i(sec_t), .min_tick_i(min_t),
    .hour_tick_i(hour_t), .mon_tick_i(mon_t), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_day_n_o(irq_day_n), .irq_wk_n_o(irq_wk_n)
  );

  // behavioural reference state
  int m_am[2], m_ah[2], m_awd, m_wk_en, m_dy_en, m_rate, m_ph, m_fl[2], m_pf;
  bit mw, md, lvl, bnd, wr_f;

  function automatic int m_pulse();
    if (m_rate == 1) return m_ph % 2;
    if (m_rate == 2) return m_ph / 2;
    return 0;
  endfunction

  function automatic int m_level();
    return (m_rate >= 3 && m_rate <= 6) ? 1 : 0;
  endfunction

  function automatic int m_day_pin();
    return ((m_fl[1] && m_dy_en) || m_pulse() != 0 || (m_level() != 0 && m_pf != 0)) ? 0 : 1;
  endfunction

  function automatic int m_read(int a);
    case (a)
      8:  return m_am[0];
      9:  return m_ah[0];
      10: return m_awd;
      11: return m_am[1];
      12: return m_ah[1];
      14: return m_wk_en * 128 + m_dy_en * 64 + m_rate;
      15: return ((m_rate == 1 || m_rate == 2) ? m_pulse() : m_pf) * 4 + m_fl[0] * 2 + m_fl[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_am[0] = 0; m_am[1] = 0; m_ah[0] = 0; m_ah[1] = 0; m_awd = 0;
      m_wk_en = 0; m_dy_en = 0; m_rate = 0; m_ph = 0;
      m_fl[0] = 0; m_fl[1] = 0; m_pf = 0;
    end else begin
      mw   = (int'(wday) == m_awd) && (int'(hour) == m_ah[0]) && (int'(min) == m_am[0]);
      md   = (int'(hour) == m_ah[1]) && (int'(min) == m_am[1]);
      lvl  = m_level() != 0;
      bnd  = (m_rate == 3 && sec_t) || (m_rate == 4 && min_t) ||
             (m_rate == 5 && hour_t) || (m_rate == 6 && mon_t);
      wr_f = we && addr == 4'hF;
      if (min_t && mw) m_fl[0] = 1; else if (wr_f && !wdata[1]) m_fl[0] = 0;
      if (min_t && md) m_fl[1] = 1; else if (wr_f && !wdata[0]) m_fl[1] = 0;
      if (lvl && bnd) m_pf = 1; else if (wr_f && !wdata[2]) m_pf = 0;
      if (we && addr == 4'hE) m_ph = 0; else if (t4) m_ph = (m_ph + 1) % 4;
      if (we) begin
        case (addr)
          4'h8: m_am[0] = wdata & 8'h7F;
          4'h9: m_ah[0] = wdata & 8'h3F;
          4'hA: m_awd   = wdata & 8'h07;
          4'hB: m_am[1] = wdata & 8'h7F;
          4'hC: m_ah[1] = wdata & 8'h3F;
          4'hE: begin m_wk_en = wdata[7]; m_dy_en = wdata[6]; m_rate = wdata & 8'h07; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 day pin", irq_day_n, m_day_pin());
      chk("R5 week pin", irq_wk_n, (m_fl[0] && m_wk_en) ? 0 : 1);
      chk("R2 rdata", rdata, m_read(addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
    we = 0; t4 = 0; sec_t = 0; min_t = 0; hour_t = 0; mon_t = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1; step();
  endtask

  task automatic rd_chk(string tag, input logic [3:0] a, int exp);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    chk("R1 day pin idle", irq_day_n, 1);
    chk("R1 week pin idle", irq_wk_n, 1);
    rd_chk("R1 ctrl", 4'hE, 0);
    rd_chk("R1 status", 4'hF, 0);

    wr(4'h8, 8'hFF); rd_chk("R2 minute mask", 4'h8, 8'h7F);
    wr(4'h9, 8'hFF); rd_chk("R2 hour mask", 4'h9, 8'h3F);
    wr(4'hA, 8'hFF); rd_chk("R2 weekday mask", 4'hA, 8'h07);
    wr(4'h3, 8'h55); rd_chk("R2 unused addr", 4'h3, 0);

    wr(4'h8, 8'h30); wr(4'h9, 8'h12); wr(4'hA, 8'h03);
    wr(4'hB, 8'h30); wr(4'hC, 8'h12);

    wday = 3'd2; hour = 6'h12; min = 7'h30;
    step(); rd_chk("R3 no set without tick", 4'hF, 0);
    min_t = 1; step();
    rd_chk("R4 daily set, R3 weekday mismatch", 4'hF, 8'h01);
    chk("R6 daily masked by enable", irq_day_n, 1);
    wr(4'hE, 8'h40); chk("R6 daily drives pin", irq_day_n, 0);
    wr(4'hF, 8'h07); rd_chk("R7 write one no effect", 4'hF, 8'h01);
    wr(4'hF, 8'h00); rd_chk("R7 write zero clears", 4'hF, 0);
    chk("R6 released after clear", irq_day_n, 1);

    wday = 3'd3; min_t = 1; step();
    rd_chk("R3 weekly set", 4'hF, 8'h03);
    chk("R5 weekly masked", irq_wk_n, 1);
    wr(4'hE, 8'hC0); chk("R5 weekly drives pin", irq_wk_n, 0);
    wr(4'hE, 8'h40); chk("R8 weekly released", irq_wk_n, 1);
    rd_chk("R8 flag kept", 4'hF, 8'h03);
    wr(4'hE, 8'h00); chk("R8 daily released", irq_day_n, 1);
    rd_chk("R8 flags kept", 4'hF, 8'h03);
    wr(4'hF, 8'h00);
    addr = 4'hF; wdata = 8'h00; we = 1; min_t = 1; step();
    rd_chk("R7 set wins over clear", 4'hF, 8'h03);
    wr(4'hF, 8'h00); rd_chk("R7 cleared", 4'hF, 0);

    hour = 6'h05;
    wr(4'hE, 8'h01); chk("R9 2Hz start high", irq_day_n, 1);
    t4 = 1; step(); chk("R9 2Hz low", irq_day_n, 0);
    rd_chk("R9 status follows pulse", 4'hF, 8'h04);
    t4 = 1; step(); chk("R9 2Hz high", irq_day_n, 1);
    step(); chk("R9 no tick holds", irq_day_n, 1);
    wr(4'hE, 8'h02);
    t4 = 1; step(); chk("R9 1Hz first tick high", irq_day_n, 1);
    t4 = 1; step(); chk("R9 1Hz low", irq_day_n, 0);
    t4 = 1; step(); chk("R9 1Hz still low", irq_day_n, 0);
    t4 = 1; step(); chk("R9 1Hz high", irq_day_n, 1);
    t4 = 1; step(); t4 = 1; step(); chk("R9 1Hz low again", irq_day_n, 0);
    wr(4'hE, 8'h02); chk("R9 restart high", irq_day_n, 1);

    wr(4'hE, 8'h03);
    min_t = 1; step(); chk("R10 wrong boundary ignored", irq_day_n, 1);
    sec_t = 1; step(); chk("R10 sec level low", irq_day_n, 0);
    rd_chk("R10 flag set", 4'hF, 8'h04);
    step(); chk("R10 level held", irq_day_n, 0);
    wr(4'hF, 8'h03); chk("R10 cleared releases", irq_day_n, 1);
    wr(4'hE, 8'h04);
    sec_t = 1; step(); chk("R10 minute ignores sec", irq_day_n, 1);
    min_t = 1; step(); chk("R10 minute level", irq_day_n, 0);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h05); hour_t = 1; step(); chk("R10 hour level", irq_day_n, 0);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h06); mon_t = 1; step(); chk("R10 month level", irq_day_n, 0);
    wr(4'hE, 8'h00); chk("R11 rate off releases", irq_day_n, 1);
    rd_chk("R10 flag still held", 4'hF, 8'h04);
    wr(4'hF, 8'h00);

    wr(4'hE, 8'h07);
    t4 = 1; sec_t = 1; min_t = 1; hour_t = 1; mon_t = 1; step();
    chk("R11 reserved rate silent", irq_day_n, 1);
    t4 = 1; step(); chk("R11 reserved no pulse", irq_day_n, 1);
    rd_chk("R11 no flag", 4'hF, 0);
    wr(4'hE, 8'h00);

    hour = 6'h12; min_t = 1; step();
    wr(4'hE, 8'h41); chk("R6 OR daily low", irq_day_n, 0);
    t4 = 1; step(); chk("R6 OR both low", irq_day_n, 0);
    t4 = 1; step(); chk("R6 OR daily only", irq_day_n, 0);
    wr(4'hF, 8'h00); chk("R6 OR both inactive", irq_day_n, 1);
    t4 = 1; step(); chk("R6 OR pulse only", irq_day_n, 0);
    wr(4'hE, 8'h00);
    step();
    summary();
  end
endmodule